// File: doc/BRIEF.md
# Link Activity Detector with Output Gating

This block watches the incoming data-enable signal of a receive link and raises a sync-detect flag while that signal keeps pulsing, which shows that the link is alive. If the pulses stop for longer than a set window, the flag drops. Before it looks for edges, the block brings data-enable into its own reference clock domain through a two-flop synchroniser. It declares the link alive only after it has seen a chosen number of rising edges, each arriving within the window of the one before it. A single stray pulse therefore does not raise the flag.

The block also applies two active-low power controls to the outputs it drives. These outputs are a registered data bus and a control bus, and each pin has its own enable.
- The output-only control turns off the data pins and every control pin except one designated control line. The sync-detect flag stays driven and detection keeps running. A system can tie the sync-detect flag back to this input, so the outputs shut off by themselves when the link drops.
- The full power-down control turns off every output, including the flag and the designated control line. It also makes the block ignore all of its inputs. When the block leaves full power-down, the detector starts again from the link-down state.

In a two-receiver pair, this block can act as the master or the slave. A master takes the peer's sync-detect flag as its single/dual-link select. A slave always reports dual-link mode.

Top module: `link_sense_gate`

## Requirements
- R1: While reset is asserted and after it is released, `syncDetect` is 0 and `dataOut` and `ctlOut` are all zeros.
- R2: `syncDetect` goes to 1 once EDGES_NEEDED (default 2) rising edges of `deIn` have been seen, each arriving within TIMEOUT reference clocks of the previous one.
- R3: `syncDetect` returns to 0 once TIMEOUT reference clocks pass with no rising edge on `deIn`. It stays 1 while rising edges keep arriving inside the window.
- R4: `syncDetect` stays 0 after a single rising edge. It also stays 0 when consecutive rising edges are more than TIMEOUT clocks apart.
- R5: While `pdAllN`=1 and `pdOutN`=0, the following hold:
  - every `dataOe` bit is 0;
  - every `ctlOe` bit is 0 except bit CTL_KEEP (default 1), which stays 1;
  - `syncOe` stays 1;
  - the detector keeps updating `syncDetect`.
- R6: While `pdAllN`=0, every bit of `dataOe` and `ctlOe` is 0 and `syncOe` is 0. Activity on `deIn` and `dataIn` has no effect.
- R7: After `pdAllN` returns to 1, `syncDetect` is 0 and needs EDGES_NEEDED fresh rising edges to go to 1 again.
- R8: With `isMaster`=1, `dualMode` equals `peerSync`. With `isMaster`=0, `dualMode` is 1.
- R9: While `pdAllN`=1, `dataOut` and `ctlOut` equal `dataIn` and `ctlIn` from one clock earlier.
- R10: When `syncDetect` is looped back to `pdOutN`, all `dataOe` bits fall to 0 after the link times out, while `syncOe` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| deIn | input | 1 | Data-enable from the link, asynchronous to clk |
| pdAllN | input | 1 | Full power-down, active low |
| pdOutN | input | 1 | Output-only power-down, active low |
| isMaster | input | 1 | 1 selects the master role in a pair |
| peerSync | input | 1 | Sync-detect flag of the peer receiver |
| dataIn | input | DATA_W | Pixel data to forward |
| ctlIn | input | CTL_W | Control bits to forward |
| syncDetect | output | 1 | Link-alive flag |
| syncOe | output | 1 | Output enable for syncDetect |
| dualMode | output | 1 | Single (0) or dual (1) link mode |
| dataOut | output | DATA_W | Registered data |
| dataOe | output | DATA_W | Per-pin enable for dataOut |
| ctlOut | output | CTL_W | Registered control bits |
| ctlOe | output | CTL_W | Per-pin enable for ctlOut |

## Verification
The hardest condition to reach from the ports is a pair of rising edges on `deIn` that both fall inside the timeout window but are spaced apart. The bench creates the opposite case first: pulses more than TIMEOUT clocks apart, during which it samples `syncDetect` on every cycle. It then sends one pulse soon after the last and expects the flag to rise. The TIMEOUT parameter is lowered to 64 so that these windows stay short. For the loopback case, the bench drives `pdOutN` directly from `syncDetect` and then stops `deIn`.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic flush;     // clear synchroniser, timer and data registers
    logic timerClr;  // hold the silence timer at zero
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_DOWN  = 2'd0,
    ST_ARMED = 2'd1,
    ST_UP    = 2'd2
  } linkState_t;

endpackage

// File: rtl/lsg_datapath.sv
module lsg_datapath
  import lsg_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int CTL_W   = 4,
  parameter int TIMEOUT = 1 << 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic              deIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CTL_W-1:0]  ctlIn,
  output logic              edgeSeen,
  output logic              timedOut,
  output logic [DATA_W-1:0] dataReg,
  output logic [CTL_W-1:0]  ctlReg
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] T_LIMIT = TW'(TIMEOUT);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   deLast;
  logic [TW-1:0]          silenceCnt;

  // Synchroniser chain into the reference domain
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)            syncChain[0] <= 1'b0;
          else if (strobe.flush) syncChain[0] <= 1'b0;
          else                   syncChain[0] <= deIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)            syncChain[g] <= 1'b0;
          else if (strobe.flush) syncChain[g] <= 1'b0;
          else                   syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            deLast <= 1'b0;
    else if (strobe.flush) deLast <= 1'b0;
    else                   deLast <= syncChain[SYNC_STAGES-1];
  end

  assign edgeSeen = syncChain[SYNC_STAGES-1] & ~deLast;

  // Silence timer: cycles since last rising edge, saturating at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          silenceCnt <= '0;
    else if (strobe.flush || strobe.timerClr || edgeSeen) silenceCnt <= '0;
    else if (silenceCnt != T_LIMIT)                      silenceCnt <= silenceCnt + 1'b1;
  end

  assign timedOut = (silenceCnt == T_LIMIT);

  // Output data registers; inputs ignored while flushed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0;
      ctlReg  <= '0;
    end else if (strobe.flush) begin
      dataReg <= '0;
      ctlReg  <= '0;
    end else begin
      dataReg <= dataIn;
      ctlReg  <= ctlIn;
    end
  end

  // R3: the timer never overruns its limit
  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    silenceCnt <= T_LIMIT);

  // R6: flushed registers show zero on the following cycle
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flush |=> (dataReg == '0) && (ctlReg == '0) && !edgeSeen);

endmodule

// File: rtl/lsg_control.sv
module lsg_control
  import lsg_pkg::*;
#(
  parameter int EDGES_NEEDED = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pdAllN,
  input  logic      edgeSeen,
  input  logic      timedOut,
  input  logic      isMaster,
  input  logic      peerSync,
  output dpStrobe_t strobe,
  output logic      linkLive,
  output logic      dualMode
);

  localparam int EW = $clog2(EDGES_NEEDED + 1);
  localparam logic [EW-1:0] E_LAST = EW'(EDGES_NEEDED - 1);

  linkState_t state, stateNx;
  logic [EW-1:0] edgeCnt, edgeCntNx;
  logic sleep;

  assign sleep = !pdAllN;

  always_comb begin
    stateNx   = state;
    edgeCntNx = edgeCnt;
    case (state)
      ST_DOWN: begin
        if (edgeSeen) begin
          edgeCntNx = EW'(1);
          stateNx   = (EDGES_NEEDED <= 1) ? ST_UP : ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (edgeSeen) begin
          if (edgeCnt >= E_LAST) begin
            stateNx   = ST_UP;
            edgeCntNx = '0;
          end else begin
            edgeCntNx = edgeCnt + 1'b1;
          end
        end else if (timedOut) begin
          stateNx   = ST_DOWN;
          edgeCntNx = '0;
        end
      end
      ST_UP: begin
        if (timedOut && !edgeSeen) begin
          stateNx   = ST_DOWN;
          edgeCntNx = '0;
        end
      end
      default: begin
        stateNx   = ST_DOWN;
        edgeCntNx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_DOWN;
      edgeCnt <= '0;
    end else if (sleep) begin
      state   <= ST_DOWN;
      edgeCnt <= '0;
    end else begin
      state   <= stateNx;
      edgeCnt <= edgeCntNx;
    end
  end

  always_comb begin
    strobe.flush    = sleep;
    strobe.timerClr = (state == ST_DOWN);
  end

  assign linkLive = (state == ST_UP);
  assign dualMode = isMaster ? peerSync : 1'b1;

  // R2: the flag only rises on a cycle that followed a detected edge
  assert_live_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linkLive) |-> $past(edgeSeen));

  // R3: silence past the window drops the flag
  assert_drop_on_silence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (linkLive && timedOut && !edgeSeen) |=> !linkLive);

  // R7: waking from full power-down starts with the link down
  assert_wake_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdAllN) |-> !linkLive);

  // R8: a slave always reports dual-link mode
  assert_slave_dual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !isMaster |-> dualMode);

endmodule

// File: rtl/link_sense_gate.sv
module link_sense_gate
  import lsg_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int CTL_W        = 4,
  parameter int CTL_KEEP     = 1,
  parameter int TIMEOUT      = 1 << 20,
  parameter int EDGES_NEEDED = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deIn,
  input  logic              pdAllN,
  input  logic              pdOutN,
  input  logic              isMaster,
  input  logic              peerSync,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CTL_W-1:0]  ctlIn,
  output logic              syncDetect,
  output logic              syncOe,
  output logic              dualMode,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [CTL_W-1:0]  ctlOe
);

  dpStrobe_t strobe;
  logic edgeSeen, timedOut, linkLive;
  logic pinsOn;

  lsg_control #(.EDGES_NEEDED(EDGES_NEEDED)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdAllN   (pdAllN),
    .edgeSeen (edgeSeen),
    .timedOut (timedOut),
    .isMaster (isMaster),
    .peerSync (peerSync),
    .strobe   (strobe),
    .linkLive (linkLive),
    .dualMode (dualMode)
  );

  lsg_datapath #(
    .DATA_W  (DATA_W),
    .CTL_W   (CTL_W),
    .TIMEOUT (TIMEOUT)
  ) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .deIn     (deIn),
    .dataIn   (dataIn),
    .ctlIn    (ctlIn),
    .edgeSeen (edgeSeen),
    .timedOut (timedOut),
    .dataReg  (dataOut),
    .ctlReg   (ctlOut)
  );

  assign pinsOn     = pdAllN && pdOutN;
  assign syncDetect = linkLive;
  assign syncOe     = pdAllN;
  assign dataOe     = {DATA_W{pinsOn}};

  genvar c;
  generate
    for (c = 0; c < CTL_W; c++) begin : gCtlOe
      if (c == CTL_KEEP) begin : gKeep
        assign ctlOe[c] = pdAllN;
      end else begin : gGate
        assign ctlOe[c] = pinsOn;
      end
    end
  endgenerate

  // R5: output-only power-down leaves the flag and the kept control line driven
  assert_keep_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pdAllN && !pdOutN) |-> (syncOe && ctlOe[CTL_KEEP] && (dataOe == '0)));

  // R6: full power-down silences every enable
  assert_full_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pdAllN |-> (!syncOe && (ctlOe == '0) && (dataOe == '0)));

endmodule

// File: tb/sim_link_sense_gate.sv
`timescale 1ns/1ps
module sim_link_sense_gate;

  localparam int DW = 24;
  localparam int CW = 4;
  localparam int KEEP = 1;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic deIn = 1'b0;
  logic pdAllN = 1'b1;
  logic pdOutDrv = 1'b1;
  logic loopMode = 1'b0;
  logic isMaster = 1'b1;
  logic peerSync = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [CW-1:0] ctlIn = '0;
  logic pdOutN;
  logic syncDetect, syncOe, dualMode;
  logic [DW-1:0] dataOut, dataOe;
  logic [CW-1:0] ctlOut, ctlOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed { logic [DW-1:0] d; logic [CW-1:0] c; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  assign pdOutN = loopMode ? syncDetect : pdOutDrv;

  link_sense_gate #(.DATA_W(DW), .CTL_W(CW), .CTL_KEEP(KEEP), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .deIn(deIn), .pdAllN(pdAllN), .pdOutN(pdOutN),
    .isMaster(isMaster), .peerSync(peerSync), .dataIn(dataIn), .ctlIn(ctlIn),
    .syncDetect(syncDetect), .syncOe(syncOe), .dualMode(dualMode),
    .dataOut(dataOut), .dataOe(dataOe), .ctlOut(ctlOut), .ctlOe(ctlOe));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one rising edge of data-enable: high for 4 cycles then low
  task automatic pulse();
    @(negedge clk) deIn = 1'b1;
    waitCyc(4);
    deIn = 1'b0;
  endtask

  task automatic toggleDe(input int nPulses);
    for (int i = 0; i < nPulses; i++) begin
      pulse();
      waitCyc(10);
    end
  endtask

  // driver: apply words and push the expected registered values
  task automatic sendWords(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dataIn = DW'(seed * 37 + i * 1013 + 5);
      ctlIn  = CW'(seed + i);
      sbq.push_back('{d: dataIn, c: ctlIn});
    end
    @(negedge clk);
  endtask

  // monitor: compare one item per clock after the register update (R9)
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t e;
      e = sbq.pop_front();
      chk(dataOut == e.d && ctlOut == e.c, "R9 data pass-through",
          {dataOut, ctlOut}, {e.d, e.c});
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int highSeen;
    waitCyc(3);
    chk(syncDetect == 0 && dataOut == 0 && ctlOut == 0, "R1 reset state",
        {syncDetect, dataOut, ctlOut}, 0);
    rst_n = 1'b1;
    waitCyc(3);
    chk(syncDetect == 0 && dataOut == 0, "R1 after release", syncDetect, 0);

    // R9: data path under two patterns
    sendWords(12, 1);
    sendWords(8, 9);

    // R4: single edge does not raise the flag
    pulse();
    highSeen = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (syncDetect) highSeen++; end
    chk(highSeen == 0, "R4 single edge", highSeen, 0);

    // R4: edges spaced beyond the window
    highSeen = 0;
    for (int p = 0; p < 3; p++) begin
      pulse();
      for (int i = 0; i < 96; i++) begin @(negedge clk); if (syncDetect) highSeen++; end
    end
    chk(highSeen == 0, "R4 spaced edges", highSeen, 0);

    // R2: a second edge inside the window raises it
    pulse();
    waitCyc(20);
    pulse();
    waitCyc(6);
    chk(syncDetect == 1, "R2 two edges in window", syncDetect, 1);
    chk(dataOe == '1 && ctlOe == '1 && syncOe, "R2 all pins driven", dataOe, 24'hffffff);

    // R3: continuous toggling keeps it up, then silence drops it
    toggleDe(6);
    chk(syncDetect == 1, "R3 stays up while toggling", syncDetect, 1);
    waitCyc(40);
    chk(syncDetect == 1, "R3 not early", syncDetect, 1);
    waitCyc(50);
    chk(syncDetect == 0, "R3 drop after silence", syncDetect, 0);

    // R5: output-only power-down; detector still runs
    pdOutDrv = 1'b0;
    waitCyc(1);
    chk(dataOe == 0 && ctlOe == CW'(1 << KEEP) && syncOe == 1, "R5 pin gating",
        {dataOe, ctlOe, syncOe}, {24'h0, CW'(1 << KEEP), 1'b1});
    toggleDe(3);
    chk(syncDetect == 1, "R5 detector runs", syncDetect, 1);
    sendWords(4, 3);
    pdOutDrv = 1'b1;

    // R6: full power-down; inputs ignored
    @(negedge clk) pdAllN = 1'b0;
    waitCyc(2);
    chk(syncOe == 0 && dataOe == 0 && ctlOe == 0, "R6 all enables off",
        {syncOe, dataOe, ctlOe}, 0);
    chk(syncDetect == 0, "R6 flag low in sleep", syncDetect, 0);
    dataIn = 24'habcdef;
    toggleDe(4);
    chk(dataOut == 0 && ctlOut == 0, "R6 data ignored", dataOut, 0);

    // R7: wake-up starts low even though DE was active
    @(negedge clk) pdAllN = 1'b1;
    waitCyc(8);
    chk(syncDetect == 0, "R7 low after wake", syncDetect, 0);
    pulse();
    waitCyc(8);
    chk(syncDetect == 0, "R7 one edge not enough", syncDetect, 0);
    pulse();
    waitCyc(6);
    chk(syncDetect == 1, "R7 up after fresh edges", syncDetect, 1);

    // R8: dual mode selection
    isMaster = 1'b1; peerSync = 1'b1; waitCyc(1);
    chk(dualMode == 1, "R8 master dual", dualMode, 1);
    peerSync = 1'b0; waitCyc(1);
    chk(dualMode == 0, "R8 master single", dualMode, 0);
    isMaster = 1'b0; waitCyc(1);
    chk(dualMode == 1, "R8 slave always dual", dualMode, 1);
    isMaster = 1'b1;

    // R10: loopback shuts outputs when the link drops
    toggleDe(3);
    loopMode = 1'b1;
    waitCyc(2);
    chk(dataOe == '1, "R10 outputs on while live", dataOe, 24'hffffff);
    waitCyc(100);
    chk(dataOe == 0 && syncOe == 1 && ctlOe == CW'(1 << KEEP), "R10 outputs off on drop",
        {dataOe, syncOe, ctlOe}, {24'h0, 1'b1, CW'(1 << KEEP)});
    loopMode = 1'b0;

    waitCyc(5);
    finishRun();
  end

endmodule